// File: doc/BRIEF.md
# First-Event Capture Register with Interrupt

This block watches a stream of event words and stores the first one that arrives while its capture register is empty. Once a word is stored, the register is full and holds that word. Later events are dropped until the register is cleared. Each capture can raise an interrupt request toward a backplane-style interrupter. The acknowledging side reads a two-bit code that goes with each request.

There are two ways to clear the register:
- A re-arm strobe, which stands in for a fetch over a command channel. It works in every mode.
- A register read of the captured word. This clears the register only when the indirect access mode is selected and clear-on-read is enabled.

In the indirect mode, software can also switch interrupts on and off through an enable register. In the direct mode that register cannot be written, and interrupts follow a configuration pin instead.

Two interrupt styles are available:
- **Paired:** a request-true service followed by a request-false service.
- **Single:** one service per capture.

Top module: `first_event_latch`

## Requirements
- R1: After reset, the register is empty, the stored word is zero, the enable register is zero, `irq_req` is low and `irq_code` is 2'b00.
- R2: An event with `evt_valid` high, arriving while the register is empty, is stored. While the register is full, further events leave the stored word unchanged.
- R3: A pulse on `rearm` empties the register in either access mode. The next event is then stored.
- R4: With `cfg_indirect`=1 and `cfg_clr_on_read`=1, a read at address 0x30 returns the stored word on `bus_rdata` one cycle after the strobe and empties the register.
- R5: With `cfg_indirect`=0, or with `cfg_clr_on_read`=0, a read at 0x30 returns the stored word and leaves the register full.
- R6: With `cfg_indirect`=1, a write to 0x38 sets the enable bit to the OR of all data bits. With `cfg_indirect`=0, such a write has no effect. A read at 0x38 returns the enable bit in bit 0.
- R7: A capture starts an interrupt only when interrupts are enabled. In indirect mode the enable is the enable bit; in direct mode it is `cfg_irq_en`. A capture with interrupts disabled leaves `irq_req` low.
- R8: With `cfg_single_irq`=1, `irq_req` rises the cycle after the capture with `irq_code`=2'b11. It falls the cycle after the first `irq_ack`.
- R9: With `cfg_single_irq`=0, a capture raises `irq_req` with `irq_code`=2'b01. The first `irq_ack` drops the request for one cycle. The request then rises again with `irq_code`=2'b10, and the second `irq_ack` releases it.
- R10: When a clear (either re-arm or clearing read) falls in the same cycle as an event, the clear wins. The event is dropped, the register ends empty, and an event on the next cycle is stored.
- R11: A read at 0x34 returns the full flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| evt_valid | input | 1 | Event strobe |
| evt_data | input | DATA_W | Event word |
| rearm | input | 1 | Command-channel clear and re-arm |
| cfg_indirect | input | 1 | 1 selects the indirect access mode |
| cfg_clr_on_read | input | 1 | Allows a read at 0x30 to clear, in indirect mode |
| cfg_single_irq | input | 1 | 1 selects the single interrupt style |
| cfg_irq_en | input | 1 | Interrupt enable used in direct mode |
| irq_req | output | 1 | Interrupt request |
| irq_code | output | 2 | 01 true, 10 false, 11 single, 00 idle |
| irq_ack | input | 1 | Acknowledge of the current request |

## Verification
The risky overlap is a clear landing in the same cycle as a new event. The clear can be a clearing read of 0x30 or a re-arm pulse. The bench provokes both forms by raising the clear and `evt_valid` together on one edge. It judges the outcome in three steps:
- The read returns the old word.
- A status read then shows the register empty.
- An event on the following cycle is stored.

A second overlap, a capture while an interrupt is still being serviced, is held for a later launch by a pending bit.

// File: rtl/first_event_latch.sv
module first_event_latch #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LATCH_OFS = 'h30,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 'h34,
  parameter logic [ADDR_W-1:0] IEN_OFS   = 'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_valid,
  input  logic [DATA_W-1:0] evt_data,
  input  logic              rearm,
  input  logic              cfg_indirect,
  input  logic              cfg_clr_on_read,
  input  logic              cfg_single_irq,
  input  logic              cfg_irq_en,
  output logic              irq_req,
  output logic [1:0]        irq_code,
  input  logic              irq_ack
);

  typedef enum logic [2:0] {S_IDLE, S_ONE, S_TRUE, S_GAP, S_FALSE} irq_st_t;

  logic [DATA_W-1:0] latch_q;
  logic              full_q;
  logic              ien_q;
  logic              pend_q;
  logic [DATA_W-1:0] rdata_q;
  irq_st_t           st_q, st_d;

  wire rd_latch = bus_rd && (bus_addr == LATCH_OFS);
  wire clr      = rearm || (rd_latch && cfg_indirect && cfg_clr_on_read);
  wire take     = evt_valid && !full_q && !clr;
  wire irq_on   = cfg_indirect ? ien_q : cfg_irq_en;
  wire fire     = take && irq_on;
  wire launch   = (st_q == S_IDLE) && (fire || pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      full_q  <= 1'b0;
    end else if (clr) begin
      full_q  <= 1'b0;
    end else if (take) begin
      latch_q <= evt_data;
      full_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ien_q <= 1'b0;
    else if (bus_wr && cfg_indirect && bus_addr == IEN_OFS)
      ien_q <= |bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (bus_rd) begin
      if (bus_addr == LATCH_OFS)     rdata_q <= latch_q;
      else if (bus_addr == STAT_OFS) rdata_q <= DATA_W'(full_q);
      else if (bus_addr == IEN_OFS)  rdata_q <= DATA_W'(ien_q);
      else                           rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (launch) st_d = cfg_single_irq ? S_ONE : S_TRUE;
      S_ONE:   if (irq_ack) st_d = S_IDLE;
      S_TRUE:  if (irq_ack) st_d = S_GAP;
      S_GAP:   st_d = S_FALSE;
      S_FALSE: if (irq_ack) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= (st_q != S_IDLE) ? (pend_q || fire) : 1'b0;
    end
  end

  assign irq_req  = (st_q == S_ONE) || (st_q == S_TRUE) || (st_q == S_FALSE);
  assign irq_code = (st_q == S_ONE)   ? 2'b11 :
                    (st_q == S_TRUE)  ? 2'b01 :
                    (st_q == S_FALSE) ? 2'b10 : 2'b00;

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !clr |=> full_q && $stable(latch_q)); // R2
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !full_q); // R10
  AST_DIRECT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !cfg_indirect && bus_addr == IEN_OFS |=> $stable(ien_q)); // R6
  AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_code == 2'b11 && irq_ack |=> !irq_req); // R8
  AST_PAIR_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_code == 2'b01 && irq_ack |=> !irq_req ##1 (irq_req && irq_code == 2'b10)); // R9

endmodule

// File: tb/first_event_latch_test.sv
module first_event_latch_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata, evt_data = '0;
  logic evt_valid = 0, rearm = 0;
  logic cfg_indirect = 0, cfg_clr_on_read = 0, cfg_single_irq = 0, cfg_irq_en = 0;
  logic irq_req, irq_ack = 0;
  logic [1:0] irq_code;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  first_event_latch uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_valid(evt_valid), .evt_data(evt_data),
    .rearm(rearm), .cfg_indirect(cfg_indirect), .cfg_clr_on_read(cfg_clr_on_read),
    .cfg_single_irq(cfg_single_irq), .cfg_irq_en(cfg_irq_en), .irq_req(irq_req),
    .irq_code(irq_code), .irq_ack(irq_ack));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_addr = a; bus_rd = 1; tick(); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; tick(); bus_wr = 0;
  endtask

  task automatic ev(input logic [DW-1:0] d);
    evt_data = d; evt_valid = 1; tick(); evt_valid = 0;
  endtask

  task automatic do_rearm();
    rearm = 1; tick(); rearm = 0;
  endtask

  task automatic ack();
    irq_ack = 1; tick(); irq_ack = 0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check(irq_req == 0 && irq_code == 0, "R1 irq idle", {irq_req, irq_code}, 0);
    rd('h34, d); check(d == 0, "R1 R11 empty", d, 0);
    rd('h30, d); check(d == 0, "R1 word zero", d, 0);
    rd('h38, d); check(d == 0, "R1 enable zero", d, 0);
  endtask

  task automatic t_direct();
    logic [DW-1:0] d;
    cfg_indirect = 0; cfg_irq_en = 0;
    ev('hA1); ev('hB2);
    rd('h30, d); check(d == 'hA1, "R2 first kept", d, 'hA1);
    rd('h34, d); check(d == 1, "R11 full flag", d, 1);
    rd('h30, d); check(d == 'hA1, "R5 direct read no clear", d, 'hA1);
    check(irq_req == 0, "R7 disabled no irq", irq_req, 0);
    do_rearm();
    rd('h34, d); check(d == 0, "R3 rearm empties", d, 0);
    ev('hC3);
    rd('h30, d); check(d == 'hC3, "R3 capture after rearm", d, 'hC3);
    do_rearm();
  endtask

  task automatic t_indirect();
    logic [DW-1:0] d;
    cfg_indirect = 1; cfg_clr_on_read = 1;
    ev('hD4);
    rd('h30, d); check(d == 'hD4, "R4 read word", d, 'hD4);
    rd('h34, d); check(d == 0, "R4 read cleared", d, 0);
    ev('hE5);
    rd('h30, d); check(d == 'hE5, "R4 recapture", d, 'hE5);
    cfg_clr_on_read = 0;
    ev('hF6);
    rd('h30, d); check(d == 'hF6, "R5 word", d, 'hF6);
    rd('h34, d); check(d == 1, "R5 no clear when disabled", d, 1);
    do_rearm();
  endtask

  task automatic t_enable();
    logic [DW-1:0] d;
    cfg_indirect = 1;
    wr('h38, 'h500); rd('h38, d); check(d == 1, "R6 nonzero enables", d, 1);
    wr('h38, 0); rd('h38, d); check(d == 0, "R6 zero disables", d, 0);
    wr('h38, 7);
    cfg_indirect = 0;
    wr('h38, 0); rd('h38, d); check(d == 1, "R6 direct write ignored", d, 1);
    cfg_indirect = 1;
  endtask

  task automatic t_single();
    cfg_indirect = 1; cfg_single_irq = 1; wr('h38, 1);
    ev('h11);
    check(irq_req == 1 && irq_code == 2'b11, "R8 R7 single raised", {irq_req, irq_code}, 3'b111);
    tick(); tick();
    check(irq_req == 1, "R8 held until ack", irq_req, 1);
    ack();
    check(irq_req == 0, "R8 released on ack", irq_req, 0);
    tick(); tick();
    check(irq_req == 0, "R8 stays low", irq_req, 0);
    do_rearm();
    wr('h38, 0);
    ev('h12); tick(); tick();
    check(irq_req == 0, "R7 disabled capture silent", irq_req, 0);
    do_rearm();
  endtask

  task automatic t_pair();
    cfg_indirect = 1; cfg_single_irq = 0; wr('h38, 1);
    ev('h21);
    check(irq_req == 1 && irq_code == 2'b01, "R9 true raised", {irq_req, irq_code}, 3'b101);
    ack();
    check(irq_req == 0, "R9 gap after first ack", irq_req, 0);
    tick();
    check(irq_req == 1 && irq_code == 2'b10, "R9 false raised", {irq_req, irq_code}, 3'b110);
    ack();
    check(irq_req == 0, "R9 released", irq_req, 0);
    tick(); tick();
    check(irq_req == 0, "R9 stays low", irq_req, 0);
    wr('h38, 0); do_rearm();
  endtask

  task automatic t_collide();
    logic [DW-1:0] d;
    cfg_indirect = 1; cfg_clr_on_read = 1;
    ev('h31);
    bus_addr = 'h30; bus_rd = 1; evt_data = 'h32; evt_valid = 1;
    tick(); bus_rd = 0; evt_valid = 0; d = bus_rdata;
    check(d == 'h31, "R10 read returns old word", d, 'h31);
    rd('h34, d); check(d == 0, "R10 read beats event", d, 0);
    ev('h33);
    rd('h30, d); check(d == 'h33, "R10 next event stored", d, 'h33);
    rearm = 1; evt_data = 'h34; evt_valid = 1; tick(); rearm = 0; evt_valid = 0;
    rd('h34, d); check(d == 0, "R10 rearm beats event", d, 0);
    evt_data = 'h35; evt_valid = 1; tick(); evt_valid = 0;
    rd('h30, d); check(d == 'h35, "R10 capture resumes", d, 'h35);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_direct();
    t_indirect();
    t_enable();
    t_single();
    t_pair();
    t_collide();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule